// File: doc/BRIEF.md
# Event-driven PWM waveform generator

The block produces one pulse-width-modulated output from a 16-bit counter. The counter runs up, down or up-and-down between zero and a programmed period. A prescaler sets the rate at which it steps. Four counter events can each change the output: reaching zero, matching the compare value while counting up, reaching the period, and matching the compare value while counting down. A small action table says what each event does to the output, so many waveform shapes come from one engine.

Software programs the block through a plain write port. The period and compare values go into buffer registers. They are copied into the active registers the counter uses under one of four load rules:

- at the next period boundary,
- immediately,
- at the next boundary after software arms a load window,
- at the turn-around point of the up-down count.

A one-cycle pulse output reports each event. An enable input starts and stops the channel. A clear strobe restarts the count.

Top module: `pwmev_top`

## Requirements
- R1: With count mode 0 (config bits [1:0]), each prescaled tick adds one to the counter. After it reaches the period value, the next tick wraps it to 0. The first tick after a start or clear moves the counter from 0 to 1.
- R2: With count mode 1, each tick subtracts one from the counter. At 0, the next tick reloads the period value. The first tick after a start moves the counter from 0 to the period.
- R3: With count mode 2, the counter climbs 0,1,…,period. It then descends to 0 and climbs again, so one full cycle is 2×period ticks.
- R4: Config fields hold the output actions:
  - zero at bits [5:4]
  - compare-up at [7:6]
  - period at [9:8]
  - compare-down at [11:10]

  The action codes are 0 (keep the level), 1 (drive low), 2 (drive high) and 3 (invert). An action is applied on the tick at which the counter arrives at the event value.
- R5: If a zero or period event falls on the same tick as a compare event, the compare event neither changes the output nor raises its pulse.
- R6: The register at address 3 sets the tick rate: one tick every N clocks, where N is the divide value (0 counts as 1). The event pulses are {zero, period, compare-up, compare-down}. Each rises on the tick at which its event happens and holds for exactly one tick.
- R7: With load rule 0 (config bits [3:2]), period and compare values written to addresses 1 and 2 take effect at the period boundary. The boundary is the wrap in mode 0, or the start of the ascent or descent from 0 in the other modes. Values also take effect on the first tick after a start.
- R8: With load rule 1, a written period or compare value is used from the first tick after the write.
- R9: With load rule 2, buffered values take effect only at a period boundary that follows a write to address 4. That write arms the load window, and each window is consumed by one load.
- R10: With load rule 3 in mode 2, buffered values take effect on the tick that leaves the period value, which is the turn-around at the top of the count.
- R11: A period value of 0 holds the counter still. No events occur and the output keeps its level.
- R12: A high level on the clear input returns the counter and prescaler to their start state without producing events. Counting resumes from 0 once clear is low.
- R13: While reset or enable is low, the output and all event pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: 0 config, 1 period, 2 compare, 3 divide, 4 arm window |
| wrData | input | DATA_W (16) | Write data |
| enable | input | 1 | Channel run enable |
| cntClr | input | 1 | Counter restart strobe |
| pwmOut | output | 1 | PWM waveform |
| evZero | output | 1 | Zero event pulse |
| evPeriod | output | 1 | Period event pulse |
| evCmpUp | output | 1 | Compare-while-rising event pulse |
| evCmpDn | output | 1 | Compare-while-falling event pulse |

## Verification
The bench uses the default parameters: a 16-bit counter, a 12-bit divider and a 16-bit write bus. It programs periods of at most 9 and a divide of 1 or 3. At these values every counting mode completes several whole cycles within a few dozen clocks. The wrap, reload and both turn-arounds therefore appear repeatedly. Each load rule is checked by writing a new compare value in mid-period and watching the exact tick on which the compare pulse moves.

// File: rtl/pwmev_pkg.sv
package pwmev_pkg;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CFG = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PRD = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMP = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_DIV = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ARM = 3'd4;
  localparam int CFG_W = 12;

  typedef enum logic [1:0] {CNT_UP = 2'd0, CNT_DOWN = 2'd1, CNT_UPDN = 2'd2, CNT_RSVD = 2'd3} cntMode_e;
  typedef enum logic [1:0] {LD_PERIOD = 2'd0, LD_IMM = 2'd1, LD_WINDOW = 2'd2, LD_CENTER = 2'd3} ldMode_e;
  typedef enum logic [1:0] {ACT_HOLD = 2'd0, ACT_LOW = 2'd1, ACT_HIGH = 2'd2, ACT_TOGGLE = 2'd3} outAct_e;

  typedef struct packed {
    outAct_e cmpDnAct;
    outAct_e prdAct;
    outAct_e cmpUpAct;
    outAct_e zeroAct;
  } actTable_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic load;
    logic cntRst;
    logic outRst;
  } strobe_t;

  function automatic logic applyAct(outAct_e a, logic cur);
    case (a)
      ACT_LOW:    applyAct = 1'b0;
      ACT_HIGH:   applyAct = 1'b1;
      ACT_TOGGLE: applyAct = ~cur;
      default:    applyAct = cur;
    endcase
  endfunction

endpackage

// File: rtl/pwmev_ctrl.sv
module pwmev_ctrl
  import pwmev_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              enable,
  input  logic              cntClr,
  input  logic              boundary,
  input  logic              centerPt,
  output strobe_t           strb,
  output cntMode_e          cntMode,
  output actTable_t         actTbl,
  output logic [CNT_W-1:0]  bufPrd,
  output logic [CNT_W-1:0]  bufCmp
);

  logic [CFG_W-1:0] cfgReg;
  logic [PSC_W-1:0] divVal;
  logic [PSC_W-1:0] divEff;
  logic [PSC_W-1:0] pscCnt;
  logic             armed;
  logic             armWr;
  logic             tickC;
  logic             loadC;
  ldMode_e          ldMode;

  assign cntMode = cntMode_e'(cfgReg[1:0]);
  assign ldMode  = ldMode_e'(cfgReg[3:2]);
  assign actTbl  = actTable_t'(cfgReg[11:4]);
  assign armWr   = wrEn && (wrAddr == ADR_ARM);

  // divide value 0 behaves as 1
  assign divEff = (divVal == '0) ? PSC_W'(1) : divVal;
  assign tickC  = enable && !cntClr && (pscCnt >= divEff - PSC_W'(1));

  always_comb begin
    case (ldMode)
      LD_IMM:    loadC = 1'b1;
      LD_WINDOW: loadC = tickC && boundary && armed;
      LD_CENTER: loadC = tickC && ((cntMode == CNT_UPDN) ? centerPt : boundary);
      default:   loadC = tickC && boundary;
    endcase
  end

  assign strb.tick   = tickC;
  assign strb.load   = loadC;
  assign strb.cntRst = !enable || cntClr;
  assign strb.outRst = !enable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
      bufPrd <= '0;
      bufCmp <= '0;
      divVal <= PSC_W'(1);
    end else if (wrEn) begin
      case (wrAddr)
        ADR_CFG: cfgReg <= wrData[CFG_W-1:0];
        ADR_PRD: bufPrd <= wrData[CNT_W-1:0];
        ADR_CMP: bufCmp <= wrData[CNT_W-1:0];
        ADR_DIV: divVal <= wrData[PSC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (armWr) begin
      armed <= 1'b1;
    end else if (loadC && ldMode == LD_WINDOW) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
    end else if (strb.cntRst || tickC) begin
      pscCnt <= '0;
    end else begin
      pscCnt <= pscCnt + PSC_W'(1);
    end
  end

  // R9: a window load consumes the arm
  a_r9_arm_drop: assert property (@(posedge clk) disable iff (!rstN)
    (armed && loadC && ldMode == LD_WINDOW && !armWr) |=> !armed);

  // R6: ticks are at least the divide value apart
  a_r6_psc_bound: assert property (@(posedge clk) disable iff (!rstN)
    (tickC && divEff > PSC_W'(1)) |=> !tickC);

endmodule

// File: rtl/pwmev_datapath.sv
module pwmev_datapath
  import pwmev_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  cntMode_e         cntMode,
  input  actTable_t        actTbl,
  input  logic [CNT_W-1:0] bufPrd,
  input  logic [CNT_W-1:0] bufCmp,
  output logic             boundary,
  output logic             centerPt,
  output logic             pwmOut,
  output logic             evZero,
  output logic             evPeriod,
  output logic             evCmpUp,
  output logic             evCmpDn
);

  logic [CNT_W-1:0] cnt, actPrd, actCmp;
  logic [CNT_W-1:0] effPrd, effCmp, nxtCnt;
  logic             dirDown, nxtDir, stepUp, stopped, fresh;
  logic             hitZ, hitP, hitCU, hitCD;
  outAct_e          selAct;

  // value in force for the step being taken
  assign effPrd = strb.load ? bufPrd : actPrd;
  assign effCmp = strb.load ? bufCmp : actCmp;

  assign boundary = fresh || ((cntMode == CNT_DOWN || cntMode == CNT_UPDN) ?
                              (cnt == '0) : (cnt >= actPrd));
  assign centerPt = fresh || (!dirDown && cnt >= actPrd);
  assign stopped  = (effPrd == '0);

  always_comb begin
    nxtCnt = cnt;
    nxtDir = dirDown;
    stepUp = 1'b0;
    if (!stopped) begin
      case (cntMode)
        CNT_DOWN: nxtCnt = (cnt == '0) ? effPrd : cnt - CNT_W'(1);
        CNT_UPDN: begin
          if (!dirDown) begin
            if (cnt >= effPrd) begin
              nxtCnt = cnt - CNT_W'(1);
              nxtDir = 1'b1;
            end else begin
              nxtCnt = cnt + CNT_W'(1);
              stepUp = 1'b1;
            end
          end else if (cnt == '0) begin
            nxtCnt = CNT_W'(1);
            nxtDir = 1'b0;
            stepUp = 1'b1;
          end else begin
            nxtCnt = cnt - CNT_W'(1);
          end
        end
        default: begin
          nxtCnt = (cnt >= effPrd) ? '0 : cnt + CNT_W'(1);
          stepUp = 1'b1;
        end
      endcase
    end
  end

  assign hitZ  = !stopped && (nxtCnt == '0);
  assign hitP  = !stopped && (nxtCnt == effPrd);
  assign hitCU = !stopped && stepUp  && (nxtCnt == effCmp) && !hitZ && !hitP;
  assign hitCD = !stopped && !stepUp && (nxtCnt == effCmp) && !hitZ && !hitP;

  always_comb begin
    if (hitZ)       selAct = actTbl.zeroAct;
    else if (hitP)  selAct = actTbl.prdAct;
    else if (hitCU) selAct = actTbl.cmpUpAct;
    else if (hitCD) selAct = actTbl.cmpDnAct;
    else            selAct = ACT_HOLD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPrd <= '0;
      actCmp <= '0;
    end else if (strb.load) begin
      actPrd <= bufPrd;
      actCmp <= bufCmp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      dirDown  <= 1'b0;
      fresh    <= 1'b1;
      evZero   <= 1'b0;
      evPeriod <= 1'b0;
      evCmpUp  <= 1'b0;
      evCmpDn  <= 1'b0;
    end else if (strb.cntRst) begin
      cnt      <= '0;
      dirDown  <= 1'b0;
      fresh    <= 1'b1;
      evZero   <= 1'b0;
      evPeriod <= 1'b0;
      evCmpUp  <= 1'b0;
      evCmpDn  <= 1'b0;
    end else if (strb.tick) begin
      cnt      <= nxtCnt;
      dirDown  <= nxtDir;
      fresh    <= 1'b0;
      evZero   <= hitZ;
      evPeriod <= hitP;
      evCmpUp  <= hitCU;
      evCmpDn  <= hitCD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pwmOut <= 1'b0;
    else if (strb.outRst) pwmOut <= 1'b0;
    else if (strb.tick)   pwmOut <= applyAct(selAct, pwmOut);
  end

  // R13: disabled channel drives low
  a_r13_off_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.outRst |=> !pwmOut);

  // R6: pulses change only on a tick or restart
  a_r6_evt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.cntRst) |=> $stable({evZero, evPeriod, evCmpUp, evCmpDn}));

  // R1: up counter wraps to zero after the period value
  a_r1_up_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntRst && cntMode == CNT_UP && !strb.load &&
     actPrd != '0 && cnt == actPrd) |=> (cnt == '0));

  // R12: clear returns the counter to zero without events
  a_r12_clr_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntRst |=> (cnt == '0 && !evZero && !evPeriod && !evCmpUp && !evCmpDn));

  // R5: compare pulse never shares a tick with zero or period
  a_r5_cmp_yield: assert property (@(posedge clk) disable iff (!rstN)
    (evZero || evPeriod) |-> !(evCmpUp || evCmpDn));

endmodule

// File: rtl/pwmev_top.sv
module pwmev_top
  import pwmev_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              enable,
  input  logic              cntClr,
  output logic              pwmOut,
  output logic              evZero,
  output logic              evPeriod,
  output logic              evCmpUp,
  output logic              evCmpDn
);

  strobe_t          strb;
  cntMode_e         cntMode;
  actTable_t        actTbl;
  logic [CNT_W-1:0] bufPrd, bufCmp;
  logic             boundary, centerPt;

  pwmev_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .enable(enable), .cntClr(cntClr), .boundary(boundary), .centerPt(centerPt),
    .strb(strb), .cntMode(cntMode), .actTbl(actTbl), .bufPrd(bufPrd), .bufCmp(bufCmp)
  );

  pwmev_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cntMode(cntMode), .actTbl(actTbl),
    .bufPrd(bufPrd), .bufCmp(bufCmp), .boundary(boundary), .centerPt(centerPt),
    .pwmOut(pwmOut), .evZero(evZero), .evPeriod(evPeriod),
    .evCmpUp(evCmpUp), .evCmpDn(evCmpDn)
  );

endmodule

// File: tb/pwmev_top_tb_top.sv
module pwmev_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        enable = 1'b0;
  logic        cntClr = 1'b0;
  logic        pwmOut, evZero, evPeriod, evCmpUp, evCmpDn;
  int          nChk = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pwmev_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .enable(enable), .cntClr(cntClr), .pwmOut(pwmOut), .evZero(evZero),
    .evPeriod(evPeriod), .evCmpUp(evCmpUp), .evCmpDn(evCmpDn)
  );

  // event vector: [3] zero, [2] period, [1] cmp-up, [0] cmp-down
  function automatic int evv();
    return {28'd0, evZero, evPeriod, evCmpUp, evCmpDn};
  endfunction

  function automatic int mkCfg(int md, int ld, int za, int cua, int pa, int cda);
    return md | (ld << 2) | (za << 4) | (cua << 6) | (pa << 8) | (cda << 10);
  endfunction

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wrReg(int a, int d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 16'(d);
    step();
    wrEn = 1'b0;
  endtask

  task automatic startRun(int cfg, int prd, int cmp, int dv, bit arm);
    enable = 1'b0; cntClr = 1'b0;
    step();
    wrReg(0, cfg); wrReg(1, prd); wrReg(2, cmp); wrReg(3, dv);
    if (arm) wrReg(4, 0);
    enable = 1'b1;
  endtask

  task automatic testReset();
    check("R13 reset out", int'(pwmOut), 0);
    check("R13 reset events", evv(), 0);
  endtask

  task automatic testUp();  // R1 R4
    startRun(mkCfg(0, 0, 2, 1, 0, 0), 4, 2, 1, 0);
    for (int k = 1; k <= 10; k++) begin
      int v;
      step();
      v = k % 5;
      check("R1 up events", evv(), ((v == 0) << 3) | ((v == 4) << 2) | ((v == 2) << 1));
      check("R4 up out", int'(pwmOut), int'(k >= 5 && v < 2));
    end
  endtask

  task automatic testDown();  // R2
    startRun(mkCfg(1, 0, 0, 0, 2, 1), 4, 2, 1, 0);
    for (int k = 1; k <= 10; k++) begin
      int v;
      step();
      v = 4 - ((k - 1) % 5);
      check("R2 down events", evv(), ((v == 0) << 3) | ((v == 4) << 2) | (v == 2));
      check("R2 down out", int'(pwmOut), int'(v > 2));
    end
  endtask

  task automatic testUpDown();  // R3
    startRun(mkCfg(2, 0, 0, 2, 0, 1), 4, 2, 1, 0);
    for (int k = 1; k <= 16; k++) begin
      int ix;
      step();
      ix = (k - 1) % 8;
      check("R3 updown events", evv(), ((ix == 7) << 3) | ((ix == 3) << 2) | ((ix == 1) << 1) | (ix == 5));
      check("R3 updown out", int'(pwmOut), int'(ix >= 1 && ix <= 4));
    end
  endtask

  task automatic testPriority();  // R5 R4 toggle
    startRun(mkCfg(0, 0, 3, 2, 0, 0), 3, 0, 1, 0);
    for (int k = 1; k <= 12; k++) begin
      step();
      check("R5 no cmp pulse at zero", evv() & 3, 0);
      check("R4 toggle out", int'(pwmOut), (k / 4) % 2);
    end
  endtask

  task automatic testPrescale();  // R6
    startRun(mkCfg(0, 0, 2, 1, 0, 0), 2, 1, 3, 0);
    step(); check("R6 no tick edge1", evv(), 0);
    step(); check("R6 no tick edge2", evv(), 0);
    for (int k = 0; k < 3; k++) begin
      step(); check("R6 cmp-up held one tick", evv(), 2);
    end
    for (int k = 0; k < 3; k++) begin
      step(); check("R6 period held one tick", evv(), 4);
    end
    check("R6 out before zero", int'(pwmOut), 0);
    step();
    check("R6 zero event", evv(), 8);
    check("R6 out after zero", int'(pwmOut), 1);
  endtask

  task automatic testLoadPeriod();  // R7
    startRun(mkCfg(0, 0, 2, 1, 0, 0), 9, 2, 1, 0);
    for (int k = 1; k <= 5; k++) step();
    wrReg(2, 7);                             // edge 6
    step(); check("R7 old cmp at 7", evCmpUp, 0);  // edge 7
    for (int k = 8; k <= 12; k++) step();
    check("R7 old cmp gone at 2", evCmpUp, 0);
    for (int k = 13; k <= 17; k++) step();
    check("R7 new cmp at 7", evCmpUp, 1);
  endtask

  task automatic testLoadImm();  // R8
    startRun(mkCfg(0, 1, 2, 1, 0, 0), 9, 2, 1, 0);
    for (int k = 1; k <= 5; k++) step();
    wrReg(2, 7);
    step(); check("R8 immediate cmp at 7", evCmpUp, 1);
  endtask

  task automatic testLoadWindow();  // R9
    startRun(mkCfg(0, 2, 2, 1, 0, 0), 9, 2, 1, 1);
    for (int k = 1; k <= 5; k++) step();
    wrReg(2, 7);
    for (int k = 7; k <= 12; k++) step();
    check("R9 unarmed keeps old cmp", evCmpUp, 1);
    for (int k = 13; k <= 17; k++) step();
    check("R9 unarmed no new cmp", evCmpUp, 0);
    for (int k = 18; k <= 22; k++) step();
    wrReg(4, 0);                             // edge 23
    for (int k = 24; k <= 27; k++) step();
    check("R9 armed waits boundary", evCmpUp, 0);
    for (int k = 28; k <= 32; k++) step();
    check("R9 old cmp replaced", evCmpUp, 0);
    for (int k = 33; k <= 37; k++) step();
    check("R9 new cmp after window", evCmpUp, 1);
  endtask

  task automatic testLoadCenter();  // R10
    startRun(mkCfg(2, 0, 0, 2, 0, 1), 4, 1, 1, 0);
    step(); check("R10 initial cmp-up", evv(), 2);
    wrReg(0, mkCfg(2, 3, 0, 2, 0, 1));        // edge 2
    wrReg(2, 3);                              // edge 3
    check("R10 no early load", evCmpUp, 0);
    step();                                   // edge 4
    step();                                   // edge 5
    check("R10 new cmp at turn-around", evCmpDn, 1);
    check("R10 out low", int'(pwmOut), 0);
    step(); step();                           // edge 7
    check("R10 old cmp gone", evCmpDn, 0);
  endtask

  task automatic testStop();  // R11
    startRun(mkCfg(0, 0, 2, 2, 2, 2), 0, 0, 1, 0);
    for (int k = 1; k <= 10; k++) begin
      step();
      check("R11 stopped events", evv(), 0);
    end
    check("R11 stopped out", int'(pwmOut), 0);
  endtask

  task automatic testClear();  // R12
    startRun(mkCfg(0, 0, 2, 1, 0, 0), 9, 5, 1, 0);
    for (int k = 1; k <= 3; k++) step();
    cntClr = 1'b1;
    step();
    check("R12 no events in clear", evv(), 0);
    cntClr = 1'b0;
    step(); check("R12 restart from 1", evv(), 0);
    for (int k = 6; k <= 9; k++) step();
    check("R12 cmp after restart", evv(), 2);
  endtask

  task automatic testDisable();  // R13
    startRun(mkCfg(0, 0, 2, 1, 0, 0), 4, 2, 1, 0);
    for (int k = 1; k <= 5; k++) step();
    check("R13 high before disable", int'(pwmOut), 1);
    enable = 1'b0;
    step();
    check("R13 out low when disabled", int'(pwmOut), 0);
    check("R13 events low when disabled", evv(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    step(); step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testUp();
    testDown();
    testUpDown();
    testPriority();
    testPrescale();
    testLoadPeriod();
    testLoadImm();
    testLoadWindow();
    testLoadCenter();
    testStop();
    testClear();
    testDisable();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule